// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block sits beside the command path of an SDRAM controller. It keeps the burst-related mode settings and produces the column address of every beat of a read or write burst. A mode-load strobe with a 12-bit operation word sets three things: the burst length, the ordering of beats (sequential or interleaved), and the CAS latency. It also sets a single-write flag that shortens write bursts. The stored CAS latency is presented on an output so the read data path can use it.

A start strobe carries a starting column and a read/write flag. In the clock cycle after that strobe is sampled, the block presents the first beat. It then moves on by one beat per clock until the final beat, and it marks that beat with a last flag. A stop strobe ends the burst early. Full-page bursts run through all 256 columns of the row and wrap without end, so only a stop or a new start can end them. A start that arrives during a burst drops the old burst and begins the new one.

Top module: `sdram_burst_colseq`

## Requirements
- R1: After reset no beat is presented (`col_valid`=0), `cas_lat` reads 2, and the stored mode is burst length 1 with sequential order and single-write off.
- R2: One clock after a sampled `mode_load`, `cas_lat` equals `mode_word[6:4]`. At all other times `cas_lat` holds its value.
- R3: The burst length comes from `mode_word[2:0]` as follows: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page. Every other code gives 1 beat.
- R4: When `mode_word[3]`=0 (sequential), the column of beat i keeps the start column's bits above the burst-length field. Its low bits are the start column's low bits plus i, wrapped to the burst length.
- R5: When `mode_word[3]`=1 (interleave), the column of beat i is the start column XOR i.
- R6: A full-page burst visits columns modulo 256 (start plus i when sequential, start XOR i when interleaved). It never raises `col_last` and it runs until a stop or a start ends it.
- R7: The first beat appears in the cycle after the start strobe is sampled. Each later beat follows one clock after the one before. `col_last` is high only on the final beat, and `col_valid` is low in the cycle after the final beat unless a new start was sampled.
- R8: A `burst_stop` that is sampled during a burst, with no start in the same cycle, makes `col_valid` low from the next cycle on.
- R9: A `burst_start` that is sampled while a burst is running wins over a stop in the same cycle. The next cycle shows beat 0 of the new burst.
- R10: When `mode_word[9]`=1, a burst started with `start_write`=1 is 1 beat long. Read bursts use the programmed length.
- R11: The length and order of a burst are fixed when it starts. A `mode_load` during the burst affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_load | input | 1 | Strobe that loads `mode_word` into the mode settings |
| mode_word | input | 12 | Mode operation word |
| burst_start | input | 1 | Strobe that begins a burst |
| start_col | input | 8 | Starting column of the burst |
| start_write | input | 1 | 1 = write burst, 0 = read burst |
| burst_stop | input | 1 | Ends the running burst |
| col_valid | output | 1 | A beat column is presented this cycle |
| col_addr | output | 8 | Column address of the current beat |
| col_last | output | 1 | The current beat is the final beat of the burst |
| cas_lat | output | 3 | Stored CAS latency field |

## Verification
The in-line assertions check the following on every cycle:
- the CAS latency loads and holds as required (R2);
- the beat index stays inside the captured length;
- `col_last` never rises in full-page mode;
- a burst ends after its last beat or after a stop;
- a start always restarts the burst at beat 0 on its captured column.

The column sequence itself is compared only in the bench. There, a behavioural model computes each expected column arithmetically, beat by beat, and the bench checks it against the design on every clock. The bench scenarios are the only evidence for these cases:
- the wrap positions inside aligned blocks;
- the interleave patterns;
- the reserved length codes;
- a full-page burst that wraps past column 255;
- the single-write shortening of write bursts;
- a mode load during a burst, which must leave that burst unchanged.

// File: rtl/colseq_pkg.sv
// Package: shared mode-word field positions and the stored mode type.
// Assumes a 12-bit mode word; field positions are fixed by the controller.
package colseq_pkg;
    localparam int MODE_W      = 12;
    localparam int BL_LSB      = 0;
    localparam int ORDER_BIT   = 3;
    localparam int CL_LSB      = 4;
    localparam int SWR_BIT     = 9;
    localparam logic [2:0] CL_RESET = 3'd2;

    typedef struct packed {
        logic [2:0] len_code;
        logic       interleave;
        logic [2:0] cl;
        logic       single_wr;
    } mode_t;
endpackage

// File: rtl/colseq_mode_reg.sv
// Module: holds the mode settings that were loaded from the mode word.
// Assumes: mode_load is a single-cycle strobe; unused word bits are dropped.
module colseq_mode_reg
    import colseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    output mode_t             mode
);
    logic unused_word_bits;
    assign unused_word_bits = ^{mode_word[11:10], mode_word[8:7]};

    // Load the mode fields on a strobe; reset to length 1, sequential, CL 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode.len_code   <= 3'b000;
            mode.interleave <= 1'b0;
            mode.cl         <= CL_RESET;
            mode.single_wr  <= 1'b0;
        end else if (mode_load) begin
            mode.len_code   <= mode_word[BL_LSB +: 3];
            mode.interleave <= mode_word[ORDER_BIT];
            mode.cl         <= mode_word[CL_LSB +: 3];
            mode.single_wr  <= mode_word[SWR_BIT];
        end
    end

    assert_cl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load |=> mode.cl == $past(mode_word[CL_LSB +: 3]));
    assert_cl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load |=> $stable(mode.cl));
endmodule

// File: rtl/colseq_len_decode.sv
// Module: turns a length code into a beat-index mask and a full-page flag.
// Assumes COL_W >= 3; reserved codes, and writes in single-write mode, give one beat.
module colseq_len_decode #(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code,
    input  logic             single_wr,
    input  logic             is_write,
    output logic [COL_W-1:0] beat_mask,
    output logic             full_page
);
    // Map the length code to a mask of (length-1); full page sets every bit.
    always_comb begin
        beat_mask = '0;
        full_page = 1'b0;
        if (!(single_wr && is_write)) begin
            unique case (len_code)
                3'b001:  beat_mask = COL_W'(1);
                3'b010:  beat_mask = COL_W'(3);
                3'b011:  beat_mask = COL_W'(7);
                3'b111: begin
                    beat_mask = '1;
                    full_page = 1'b1;
                end
                default: beat_mask = '0;
            endcase
        end
    end
endmodule

// File: rtl/colseq_addr_map.sv
// Module: forms the beat column from the start column, beat index and order.
// Assumes the index never has bits set outside the mask (the sequencer keeps this true).
module colseq_addr_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [COL_W-1:0] beat_mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] xor_val;

    // Sum and XOR candidates for the low (in-burst) bits.
    always_comb begin
        seq_sum = base_col + beat_idx;
        xor_val = base_col ^ beat_idx;
    end

    // Per bit: above the mask keep the start column, inside it pick the order.
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        always_comb begin
            if (!beat_mask[b])
                col[b] = base_col[b];
            else if (interleave)
                col[b] = xor_val[b];
            else
                col[b] = seq_sum[b];
        end
    end
endmodule

// File: rtl/colseq_beat_seq.sv
// Module: burst state - running flag, captured start column, length, order and beat index.
// Assumes a start wins over a stop in the same cycle; a full-page burst ends only by stop or start.
module colseq_beat_seq #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             burst_start,
    input  logic [COL_W-1:0] start_col,
    input  logic             burst_stop,
    input  logic [COL_W-1:0] new_mask,
    input  logic             new_full,
    input  logic             new_interleave,
    output logic             active,
    output logic [COL_W-1:0] base_col,
    output logic [COL_W-1:0] beat_idx,
    output logic [COL_W-1:0] beat_mask,
    output logic             interleave,
    output logic             last_beat
);
    logic full_q;

    // The final beat is the index equal to the mask; full page has none.
    always_comb last_beat = active && !full_q && (beat_idx == beat_mask);

    // Capture a burst on start, advance one beat per clock, end on last or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            base_col   <= '0;
            beat_idx   <= '0;
            beat_mask  <= '0;
            full_q     <= 1'b0;
            interleave <= 1'b0;
        end else if (burst_start) begin
            active     <= 1'b1;
            base_col   <= start_col;
            beat_idx   <= '0;
            beat_mask  <= new_mask;
            full_q     <= new_full;
            interleave <= new_interleave;
        end else if (active) begin
            if (burst_stop || last_beat)
                active <= 1'b0;
            else
                beat_idx <= beat_idx + 1'b1;
        end
    end

    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((beat_idx & ~beat_mask) == '0));
    assert_full_nolast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && full_q) |-> !last_beat);
    assert_end_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !burst_start) |=> !active);
    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && burst_stop && !burst_start) |=> !active);
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> (active && beat_idx == '0 && base_col == $past(start_col)));
endmodule

// File: rtl/sdram_burst_colseq.sv
// Module: top of the burst column sequencer - mode settings, length decode,
// burst state and column mapping.
// Assumes strobes are single-cycle; outputs are combinational from registers.
module sdram_burst_colseq
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              burst_start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              start_write,
    input  logic              burst_stop,
    output logic              col_valid,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_last,
    output logic [2:0]        cas_lat
);
    mode_t            mode;
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             active;
    logic [COL_W-1:0] base_col;
    logic [COL_W-1:0] beat_idx;
    logic [COL_W-1:0] beat_mask;
    logic             interleave;
    logic             last_beat;

    colseq_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_load (mode_load),
        .mode_word (mode_word),
        .mode      (mode)
    );

    colseq_len_decode #(.COL_W(COL_W)) u_len (
        .len_code  (mode.len_code),
        .single_wr (mode.single_wr),
        .is_write  (start_write),
        .beat_mask (dec_mask),
        .full_page (dec_full)
    );

    colseq_beat_seq #(.COL_W(COL_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .burst_start    (burst_start),
        .start_col      (start_col),
        .burst_stop     (burst_stop),
        .new_mask       (dec_mask),
        .new_full       (dec_full),
        .new_interleave (mode.interleave),
        .active         (active),
        .base_col       (base_col),
        .beat_idx       (beat_idx),
        .beat_mask      (beat_mask),
        .interleave     (interleave),
        .last_beat      (last_beat)
    );

    colseq_addr_map #(.COL_W(COL_W)) u_map (
        .base_col   (base_col),
        .beat_idx   (beat_idx),
        .beat_mask  (beat_mask),
        .interleave (interleave),
        .col        (col_addr)
    );

    // Drive the outputs from the burst state and the stored mode.
    always_comb begin
        col_valid = active;
        col_last  = last_beat;
        cas_lat   = mode.cl;
    end

    assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);
endmodule

// File: tb/sim_sdram_burst_colseq.sv
`timescale 1ns/1ps
module sim_sdram_burst_colseq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_load = 1'b0;
    logic [11:0] mode_word = '0;
    logic        burst_start = 1'b0;
    logic [7:0]  start_col = '0;
    logic        start_write = 1'b0;
    logic        burst_stop = 1'b0;
    logic        col_valid;
    logic [7:0]  col_addr;
    logic        col_last;
    logic [2:0]  cas_lat;

    int total = 0;
    int bad = 0;
    string req = "R1";

    always #2 clk = ~clk;

    sdram_burst_colseq u0 (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
        .burst_start(burst_start), .start_col(start_col), .start_write(start_write),
        .burst_stop(burst_stop), .col_valid(col_valid), .col_addr(col_addr),
        .col_last(col_last), .cas_lat(cas_lat)
    );

    // Behavioural reference model: integers only.
    int m_code = 0, m_ilv = 0, m_cl = 2, m_sw = 0;
    int m_act = 0, m_base = 0, m_idx = 0, m_len = 1, m_full = 0, m_bilv = 0;

    function automatic int code_len(input int c);
        case (c)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 256;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0; m_ilv = 0; m_cl = 2; m_sw = 0; m_act = 0; m_idx = 0;
        end else begin
            if (burst_start) begin
                m_act = 1; m_base = start_col; m_idx = 0; m_bilv = m_ilv;
                m_len = code_len(m_code); m_full = (m_code == 7);
                if (start_write && m_sw == 1) begin m_len = 1; m_full = 0; end
            end else if (m_act == 1) begin
                if (burst_stop || (m_full == 0 && m_idx == m_len - 1)) m_act = 0;
                else m_idx = (m_idx + 1) % 256;
            end
            if (mode_load) begin
                m_code = mode_word & 7; m_ilv = (mode_word >> 3) & 1;
                m_cl = (mode_word >> 4) & 7; m_sw = (mode_word >> 9) & 1;
            end
        end
    end

    function automatic int exp_col();
        int blk;
        if (m_bilv == 1) return (m_base ^ m_idx) & 255;
        blk = m_base - (m_base % m_len);
        return blk + ((m_base % m_len) + m_idx) % m_len;
    endfunction

    task automatic check(input string r, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    // Advance one clock, then compare all outputs at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check(req, "col_valid", col_valid, m_act);
        check("R2", "cas_lat", cas_lat, m_cl);
        if (m_act == 1) begin
            check(req, "col_addr", col_addr, exp_col());
            check(req, "col_last", col_last, (m_full == 0 && m_idx == m_len - 1));
        end
    endtask

    task automatic load_mode(input logic [11:0] w);
        mode_word = w; mode_load = 1'b1;
        tick();
        mode_load = 1'b0;
    endtask

    task automatic begin_burst(input logic [7:0] c, input logic wr);
        start_col = c; start_write = wr; burst_start = 1'b1;
        tick();
        burst_start = 1'b0; start_write = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic stop_now();
        burst_stop = 1'b1;
        tick();
        burst_stop = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "reset col_valid", col_valid, 0);
        check("R1", "reset cas_lat", cas_lat, 2);
        req = "R1"; begin_burst(8'h05, 1'b0); run(2);            // default length 1
        req = "R2"; load_mode(12'h032); run(1);                   // CL 3, length 4 seq
        req = "R4"; begin_burst(8'h0E, 1'b0); run(5);             // 0E 0F 0C 0D
        req = "R4"; load_mode(12'h021); begin_burst(8'h11, 1'b0); run(3);
        req = "R5"; load_mode(12'h02B); begin_burst(8'h25, 1'b0); run(9);
        req = "R3"; load_mode(12'h024); begin_burst(8'h77, 1'b0); run(2); // reserved 100
        req = "R3"; load_mode(12'h036); begin_burst(8'h78, 1'b0); run(2); // reserved 110
        req = "R6"; load_mode(12'h027); begin_burst(8'hF0, 1'b0); run(300);
        req = "R8"; stop_now(); run(2);
        req = "R6"; load_mode(12'h03F); begin_burst(8'h3C, 1'b0); run(40);
        req = "R8"; stop_now(); run(1);
        req = "R8"; load_mode(12'h023); begin_burst(8'h40, 1'b0); run(3); stop_now(); run(2);
        req = "R9"; begin_burst(8'h80, 1'b0); run(2); begin_burst(8'h9A, 1'b0); run(10);
        req = "R9"; begin_burst(8'hA0, 1'b0); burst_stop = 1'b1; begin_burst(8'hB3, 1'b0);
        burst_stop = 1'b0; run(9);
        req = "R10"; load_mode(12'h222); begin_burst(8'h13, 1'b1); run(3);
        req = "R10"; begin_burst(8'h13, 1'b0); run(5);
        req = "R10"; load_mode(12'h022); begin_burst(8'h2D, 1'b1); run(5);
        req = "R11"; load_mode(12'h03B); begin_burst(8'h51, 1'b0); run(1);
        mode_word = 12'h021; mode_load = 1'b1; tick(); mode_load = 1'b0; run(8);
        req = "R11"; begin_burst(8'h51, 1'b0); run(3);
        req = "R7"; load_mode(12'h023); begin_burst(8'hFE, 1'b0); run(9);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule